// File: doc/BRIEF.md
# Slow-Clock Counter with Match Interrupt

This peripheral keeps a free-running counter in a slow clock domain (nominally 32.768 kHz) and exposes it through a simple register port clocked by a fast system clock. Software programs a prescale value, loads the counter and sets a compare value. Each of those three writes is posted into the slow domain. A per-register busy flag stays set until the slow domain has applied the value. While a register's busy flag is set, further writes to that register are dropped.

When the counter steps onto the compare value, a status bit is set and drives a level interrupt. The status bit stays set until software writes 1 to it. A control/status word also carries an oscillator-enable bit, which drives a pin to the oscillator, and a sticky bit that reports that the slow clock has been seen toggling. Counter reads return a snapshot that the bus domain copies while the slow value is stable, so a read never returns a mix of two counter values. This requires the bus clock to be several times faster than the slow clock.

Register word addresses:
- 0: control/status. Bit 0 is oscillator enable (read/write). Bit 1 is slow clock detected (read-only). Bit 2 is prescale busy, bit 3 is counter-load busy and bit 4 is compare busy (all read-only). Bit 5 is the match interrupt status, cleared by writing 1.
- 1: prescale value.
- 2: counter. A write loads the counter; a read returns the snapshot.
- 3: compare value.

Top module: `slow_match_timer`

## Requirements
- R1: After reset every register word reads 0, `irq` is 0 and `osc_en` is 0.
- R2: Bit 1 of word 0 reads 0 until the slow clock has toggled. It then reads 1 and stays 1 even if the slow clock stops, until reset.
- R3: Bit 0 of word 0 is written by any write to word 0, reads back as written, and drives `osc_en`.
- R4: With prescale 0 the counter advances by one on every slow-clock rising edge. With prescale N it advances once every N+1 slow edges.
- R5: A write to word 2 sets busy bit 3. Bit 3 clears once the slow-domain counter holds the written value, after which counter reads continue upward from that value.
- R6: A write to word 1, 2 or 3 while that word's busy bit (2, 3 or 4) is set is ignored. The earlier value is the one that is applied and read back.
- R7: When the counter increments to a value equal to the compare value, bit 5 of word 0 and `irq` become 1. They stay 1 until a write to word 0 with bit 5 set, which clears both.
- R8: The counter wraps from its all-ones value to 0 and keeps counting.
- R9: A write to word 1 or word 3 sets busy bit 2 or busy bit 4 respectively. The bit clears by itself within a few slow-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Slow counter clock |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| osc_en | output | 1 | Oscillator enable |
| irq | output | 1 | Match interrupt, level |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit prescale field. An 8-bit counter brings the wrap from 0xFF to 0 within a few slow cycles. A 4-bit prescale field still allows divide-by-four to be measured exactly. The slow clock runs at one sixteenth of the bus clock, so counts taken a whole number of slow periods apart are exact, and the round trip of every busy flag fits in a short poll. The slow clock starts stopped and is stopped again at the end, which shows both the initial 0 and the sticky 1 of the detect bit.

// File: rtl/slow_match_timer.sv
module slow_match_timer #(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              osc_en,
  output logic              irq
);
  localparam int NREG = 3;

  // bus-side shadows and request toggles (0 trim, 1 count, 2 compare)
  logic [TRIM_W-1:0] trim_sh;
  logic [CNT_W-1:0]  cnt_sh, cmp_sh, cnt_rd;
  logic [NREG-1:0]   req_t, ack_m, ack_b, pend;
  logic              ph_m, ph_b, ph_d, m_m, m_b, m_d, det, irq_st, osc_q;

  // slow-side state
  logic [NREG-1:0]   rq_m, rq_b, rq_d, apply;
  logic [TRIM_W-1:0] trim_s, pdiv;
  logic [CNT_W-1:0]  cnt, cmp_s, cnt_inc;
  logic              ph, m_t, tick;

  assign pend    = req_t ^ ack_b;
  assign apply   = rq_b ^ rq_d;
  assign tick    = (pdiv == trim_s);
  assign cnt_inc = cnt + 1'b1;
  assign osc_en  = osc_q;
  assign irq     = irq_st;

  wire wr_ctl  = wr && addr == 2'd0;
  wire wr_trim = wr && addr == 2'd1 && !pend[0];
  wire wr_cnt  = wr && addr == 2'd2 && !pend[1];
  wire wr_cmp  = wr && addr == 2'd3 && !pend[2];
  wire irq_clr = wr_ctl && wdata[5];
  wire irq_set = m_b ^ m_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_sh <= '0; cnt_sh <= '0; cmp_sh <= '0; cnt_rd <= '0;
      req_t <= '0; ack_m <= '0; ack_b <= '0;
      ph_m <= 1'b0; ph_b <= 1'b0; ph_d <= 1'b0;
      m_m <= 1'b0; m_b <= 1'b0; m_d <= 1'b0;
      det <= 1'b0; irq_st <= 1'b0; osc_q <= 1'b0;
    end else begin
      ack_m <= rq_d;  ack_b <= ack_m;
      ph_m  <= ph;    ph_b  <= ph_m;  ph_d <= ph_b;
      m_m   <= m_t;   m_b   <= m_m;   m_d  <= m_b;
      if (ph_b ^ ph_d) begin
        cnt_rd <= cnt;
        det    <= 1'b1;
      end
      if (irq_set)      irq_st <= 1'b1;
      else if (irq_clr) irq_st <= 1'b0;
      if (wr_ctl) osc_q <= wdata[0];
      if (wr_trim) begin trim_sh <= wdata[TRIM_W-1:0]; req_t[0] <= ~req_t[0]; end
      if (wr_cnt)  begin cnt_sh  <= wdata[CNT_W-1:0];  req_t[1] <= ~req_t[1]; end
      if (wr_cmp)  begin cmp_sh  <= wdata[CNT_W-1:0];  req_t[2] <= ~req_t[2]; end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rq_m <= '0; rq_b <= '0; rq_d <= '0;
      trim_s <= '0; pdiv <= '0; cnt <= '0; cmp_s <= '0;
      ph <= 1'b0; m_t <= 1'b0;
    end else begin
      rq_m <= req_t; rq_b <= rq_m; rq_d <= rq_b;
      ph   <= ~ph;
      if (apply[0]) begin
        trim_s <= trim_sh;
        pdiv   <= '0;
      end else begin
        pdiv <= tick ? '0 : pdiv + 1'b1;
      end
      if (apply[1])  cnt <= cnt_sh;
      else if (tick) cnt <= cnt_inc;
      if (apply[2]) cmp_s <= cmp_sh;
      if (!apply[1] && tick && cnt_inc == cmp_s) m_t <= ~m_t;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[5:0]        = {irq_st, pend, det, osc_q};
      2'd1: rdata[TRIM_W-1:0] = trim_sh;
      2'd2: rdata[CNT_W-1:0]  = cnt_rd;
      default: rdata[CNT_W-1:0] = cmp_sh;
    endcase
  end

  AST_DET_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) det |=> det); // R2
  AST_OSC_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n) wr_ctl |=> osc_en == $past(wdata[0])); // R3
  AST_CNT_HOLD:     assert property (@(posedge sclk) disable iff (!rst_n) (!apply[1] && !tick) |=> $stable(cnt)); // R4
  AST_TRIM_DROP:    assert property (@(posedge clk) disable iff (!rst_n) (wr && addr == 2'd1 && pend[0]) |=> $stable(trim_sh)); // R6
  AST_CMP_DROP:     assert property (@(posedge clk) disable iff (!rst_n) (wr && addr == 2'd3 && pend[2]) |=> $stable(cmp_sh)); // R6
  AST_IRQ_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_clr) |=> irq); // R7
  AST_IRQ_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) (irq_clr && !irq_set) |=> !irq); // R7
  AST_PEND_ON_WR:   assert property (@(posedge clk) disable iff (!rst_n) wr_cmp |=> pend[2]); // R9
endmodule

// File: tb/slow_match_timer_tb.sv
module slow_match_timer_tb;
  localparam int CW = 8;
  localparam int TW = 4;
  localparam int DW = 32;
  localparam int SP = 16;

  logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0, wr = 1'b0, srun = 1'b0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic osc_en, irq;
  int checks = 0, fails = 0;

  slow_match_timer #(.CNT_W(CW), .TRIM_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .osc_en(osc_en), .irq(irq));

  always #5 clk = ~clk;
  always #80 if (srun) sclk = ~sclk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(int bitn);
    logic [DW-1:0] s;
    for (int i = 0; i < 400; i++) begin
      rreg(2'd0, s);
      if (!s[bitn]) return;
    end
    check("R9 busy clear", s[bitn], 1'b0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    for (int a = 0; a < 4; a++) begin
      rreg(a[1:0], v);
      check("R1 reset word", v, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 osc_en", osc_en, 0);
  endtask

  task automatic t_detect_off();
    logic [DW-1:0] v;
    repeat (50) @(negedge clk);
    rreg(2'd0, v);
    check("R2 detect before slow clock", v[1], 0);
  endtask

  task automatic t_osc();
    logic [DW-1:0] v;
    wreg(2'd0, 32'h1);
    rreg(2'd0, v);
    check("R3 osc bit", v[0], 1);
    check("R3 osc pin", osc_en, 1);
  endtask

  task automatic t_detect_on();
    logic [DW-1:0] v;
    srun = 1'b1;
    repeat (10 * SP) @(negedge clk);
    rreg(2'd0, v);
    check("R2 detect after slow clock", v[1], 1);
  endtask

  task automatic t_rate0();
    logic [DW-1:0] a, b;
    rreg(2'd2, a);
    repeat (10 * SP - 1) @(negedge clk);
    rreg(2'd2, b);
    check("R4 prescale 0 rate", (b - a) & 8'hFF, 10);
  endtask

  task automatic t_trim();
    logic [DW-1:0] v, a, b;
    wreg(2'd1, 32'h3);
    wreg(2'd1, 32'h7);
    rreg(2'd0, v);
    check("R9 prescale busy set", v[2], 1);
    wait_idle(2);
    rreg(2'd1, v);
    check("R6 dropped prescale write", v, 3);
    repeat (4 * SP) @(negedge clk);
    rreg(2'd2, a);
    repeat (32 * SP - 1) @(negedge clk);
    rreg(2'd2, b);
    check("R4 prescale 3 rate", (b - a) & 8'hFF, 8);
    wreg(2'd1, 32'h0);
    wait_idle(2);
  endtask

  task automatic t_load();
    logic [DW-1:0] v;
    wreg(2'd2, 32'h40);
    wreg(2'd2, 32'h90);
    rreg(2'd0, v);
    check("R5 count busy set", v[3], 1);
    wait_idle(3);
    repeat (3 * SP) @(negedge clk);
    rreg(2'd2, v);
    check("R5 loaded value near 40h", (v >= 32'h40 && v <= 32'h48), 1);
    check("R6 dropped count write", (v >= 32'h90), 0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] v;
    wreg(2'd2, 32'hFD);
    wait_idle(3);
    repeat (8 * SP) @(negedge clk);
    rreg(2'd2, v);
    check("R8 wrapped below 10h", (v < 32'h10), 1);
  endtask

  task automatic t_match();
    logic [DW-1:0] v;
    wreg(2'd3, 32'h30);
    wreg(2'd3, 32'h55);
    rreg(2'd0, v);
    check("R9 compare busy set", v[4], 1);
    wait_idle(4);
    rreg(2'd3, v);
    check("R6 dropped compare write", v, 32'h30);
    wreg(2'd2, 32'h28);
    wait_idle(3);
    wreg(2'd0, 32'h21);
    repeat (2) @(negedge clk);
    check("R7 irq low before match", irq, 0);
    repeat (20 * SP) @(negedge clk);
    check("R7 irq after match", irq, 1);
    rreg(2'd0, v);
    check("R7 status bit", v[5], 1);
    repeat (10 * SP) @(negedge clk);
    check("R7 irq held", irq, 1);
    wreg(2'd0, 32'h21);
    check("R7 irq cleared", irq, 0);
    rreg(2'd0, v);
    check("R7 status cleared", v[5], 0);
    check("R3 osc kept by clear write", v[0], 1);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] v;
    srun = 1'b0;
    repeat (20 * SP) @(negedge clk);
    rreg(2'd0, v);
    check("R2 detect sticky with clock stopped", v[1], 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_detect_off();
    t_osc();
    t_detect_on();
    t_rate0();
    t_trim();
    t_load();
    t_wrap();
    t_match();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule